// File: doc/BRIEF.md
# Dual-Converter Status Flag Register

This block holds the eight status flags of a two-channel converter, with a main channel and an auxiliary channel. Event pulses from the rest of the converter drive each flag. These events are: a result landing in a channel's data register, a finished calibration, a clamped result, a failed calibration, an upcoming result write, a read of a channel's data register, and a write to the mode bits that starts new work. Two level inputs are also captured: the reference-fault detector, which only counts while the main channel is enabled, and the clock-synthesizer lock.

The flag byte is read in two ways. It appears on a parallel read port when the register address selects it. It can also be shifted out one bit per clock, most significant bit first, after a serial start strobe. The block also exports a force-ones level, which tells the main channel's result path to saturate its output while the reference is missing.

Each flag has its own set and clear sources. When a set and a clear hit the same flag in the same cycle, the set wins.

Top module: `conv_status_reg`

## Requirements
- R1: After reset, every flag is 0, so the byte reads 0x00, and the serial output is idle.
- R2: With `reg_addr` equal to 0 (the status address), `rd_data` shows the byte with bit 7 = main ready, bit 6 = aux ready, bit 5 = calibration done, bit 4 = reference missing, bit 3 = main error, bit 2 = aux error, bit 1 = always 0, and bit 0 = clock lock. Any other address reads 0x00.
- R3: A channel's ready flag (channel 0 = main, channel 1 = aux, as bit 0 and bit 1 of each per-channel input vector) is set on the clock after that channel's `res_wr` or `cal_done` pulse. A set wins over any clear in the same cycle.
- R4: A channel's ready flag is cleared on the clock after a `data_rd` or `upd_pend` pulse for that channel, unless a set arrives in the same cycle.
- R5: A `mode_wr` pulse clears both ready flags, the calibration flag and both error flags on the next clock, unless a set arrives in the same cycle. With no event, every flag holds its value.
- R6: The calibration flag is set on the clock after either channel's `cal_done`, in the same cycle that the ready flag of that channel rises.
- R7: The reference-missing flag equals `main_en & ref_fault`, registered one clock. `main_force_ones` equals this flag.
- R8: An error flag is set when its channel's result write comes with `clamp`, or when its channel's `cal_done` comes with `cal_fault`. For the main channel, a result write while the reference-missing flag is set also counts as clamped.
- R9: The lock bit follows `pll_lock` through `LOCK_STAGES` registers (default 2).
- R10: A `ser_start` pulse with the status address selected captures the byte at that clock edge. `ser_out` then shows bit 7 in the following cycle, and bits 6 down to 0 in the next seven cycles, while `ser_busy` is high. A start is ignored while more than one bit is still waiting to be sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Register address for parallel and serial reads |
| rd_data | output | 8 | Parallel read data |
| ser_start | input | 1 | Start a serial read of the addressed register |
| ser_out | output | 1 | Serial data, MSB first |
| ser_busy | output | 1 | Serial shift in progress |
| res_wr | input | 2 | Result written to the channel data register |
| cal_done | input | 2 | Calibration cycle completed |
| clamp | input | 2 | Result being written is clamped (valid with res_wr) |
| cal_fault | input | 2 | Calibration coefficients were not written (valid with cal_done) |
| upd_pend | input | 2 | Result update coming soon; early clear of ready |
| data_rd | input | 2 | Channel data register has been read |
| mode_wr | input | 1 | Mode write that starts a conversion or calibration |
| main_en | input | 1 | Main channel enabled |
| ref_fault | input | 1 | Reference fault detector level |
| pll_lock | input | 1 | Clock synthesizer lock level |
| main_force_ones | output | 1 | Main result path must saturate to all ones |

## Verification
The collision that matters is a set and a clear on the same flag in one cycle. Examples are a result write together with a data read or an update-pending pulse, and a calibration completion together with a mode write. Directed sequences put these pairs on the same edge on purpose. A long random phase then produces them by chance, both per channel and across channels. A behavioural model in the bench, in which every set takes priority, judges each cycle's byte. The same model checks the serial stream, including starts issued in its final bit.

// File: rtl/cstat_pkg.sv
package cstat_pkg;
   localparam int STAT_W  = 8;
   localparam int N_CH    = 2;
   localparam int B_RDY_M = 7;
   localparam int B_RDY_A = 6;
   localparam int B_CAL   = 5;
   localparam int B_NOREF = 4;
   localparam int B_ERR_M = 3;
   localparam int B_ERR_A = 2;
   localparam int B_RSVD  = 1;
   localparam int B_LOCK  = 0;
endpackage

// File: rtl/cstat_flag.sv
module cstat_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   // R3: set has priority
   a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   // R4: clear alone drops the flag
   a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
   // R5: no event holds the flag
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/cstat_serializer.sv
module cstat_serializer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] data_i,
   output logic         bit_o,
   output logic         busy_o
);
   localparam int CW = $clog2(W + 1);

   if (W < 2) begin : g_bad_w
      $error("cstat_serializer: W must be at least 2");
   end

   logic [W-1:0]  sh_q;
   logic [CW-1:0] cnt_q;
   logic          take;

   assign take = load_i && (cnt_q <= CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (take) begin
         sh_q  <= data_i;
         cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
         sh_q  <= {sh_q[W-2:0], 1'b0};
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign bit_o  = sh_q[W-1];
   assign busy_o = (cnt_q != '0);

   // R10: first bit after a start is the captured MSB
   a_r10_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (bit_o == $past(data_i[W-1])));
   a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> busy_o);
endmodule

// File: rtl/conv_status_reg.sv
module conv_status_reg
   import cstat_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int STAT_ADDR   = 0,
   parameter int LOCK_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   output logic [7:0]        rd_data,
   input  logic              ser_start,
   output logic              ser_out,
   output logic              ser_busy,
   input  logic [1:0]        res_wr,
   input  logic [1:0]        cal_done,
   input  logic [1:0]        clamp,
   input  logic [1:0]        cal_fault,
   input  logic [1:0]        upd_pend,
   input  logic [1:0]        data_rd,
   input  logic              mode_wr,
   input  logic              main_en,
   input  logic              ref_fault,
   input  logic              pll_lock,
   output logic              main_force_ones
);
   localparam logic [ADDR_W-1:0] SEL = ADDR_W'(STAT_ADDR);

   if (ADDR_W < 1 || STAT_ADDR < 0 || STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("conv_status_reg: STAT_ADDR does not fit ADDR_W");
   end
   if (LOCK_STAGES < 0 || LOCK_STAGES > 4) begin : g_bad_lock
      $error("conv_status_reg: LOCK_STAGES must be 0..4");
   end

   logic [N_CH-1:0]   rdy, err, clamp_eff;
   logic              cal_q, noref_q, lock_bit, selected;
   logic [STAT_W-1:0] stat;

   // reference-missing flag, gated by main channel enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) noref_q <= 1'b0;
      else        noref_q <= main_en & ref_fault;
   end
   assign main_force_ones = noref_q;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign clamp_eff[c] = clamp[c] | ((c == 0) ? noref_q : 1'b0);

      cstat_flag u_rdy (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (res_wr[c] | cal_done[c]),
         .clr_i (data_rd[c] | upd_pend[c] | mode_wr),
         .q_o   (rdy[c])
      );

      cstat_flag u_err (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i ((res_wr[c] & clamp_eff[c]) | (cal_done[c] & cal_fault[c])),
         .clr_i (mode_wr),
         .q_o   (err[c])
      );
   end

   cstat_flag u_cal (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (|cal_done),
      .clr_i (mode_wr),
      .q_o   (cal_q)
   );

   if (LOCK_STAGES == 0) begin : g_lock_direct
      assign lock_bit = pll_lock;
   end else begin : g_lock_sync
      logic [LOCK_STAGES-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '0;
         else begin
            pipe_q[0] <= pll_lock;
            for (int s = 1; s < LOCK_STAGES; s++) pipe_q[s] <= pipe_q[s-1];
         end
      end
      assign lock_bit = pipe_q[LOCK_STAGES-1];
   end

   always_comb begin
      stat          = '0;
      stat[B_RDY_M] = rdy[0];
      stat[B_RDY_A] = rdy[1];
      stat[B_CAL]   = cal_q;
      stat[B_NOREF] = noref_q;
      stat[B_ERR_M] = err[0];
      stat[B_ERR_A] = err[1];
      stat[B_RSVD]  = 1'b0;
      stat[B_LOCK]  = lock_bit;
   end

   assign selected = (reg_addr == SEL);
   assign rd_data  = selected ? stat : '0;

   cstat_serializer #(.W(STAT_W)) u_ser (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ser_start & selected),
      .data_i (stat),
      .bit_o  (ser_out),
      .busy_o (ser_busy)
   );

   // R6: calibration flag only rises together with a ready flag
   a_r6_cal_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_q) |-> (rdy != '0));
   // R7: reference fault with main enabled raises the flag next clock
   a_r7_noref_track: assert property (@(posedge clk) disable iff (!rst_n)
      (main_en && ref_fault) |=> main_force_ones);
   // R8: main result written without reference is flagged as error
   a_r8_err_on_noref: assert property (@(posedge clk) disable iff (!rst_n)
      (res_wr[0] && main_force_ones) |=> err[0]);
   // R5: mode write with no competing set clears the shared flags
   a_r5_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && res_wr == '0 && cal_done == '0) |=> (rdy == '0 && !cal_q && err == '0));
endmodule

// File: tb/conv_status_reg_test.sv
module conv_status_reg_test;
   localparam int CLK_P     = 10;
   localparam int PEND_LEAD = 4;
   localparam int WDOG      = 200000;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] rd_data;
   logic       ser_start = 0, ser_out, ser_busy;
   logic [1:0] res_wr = 0, cal_done = 0, clamp = 0, cal_fault = 0, upd_pend = 0, data_rd = 0;
   logic       mode_wr = 0, main_en = 0, ref_fault = 0, pll_lock = 0, main_force_ones;

   int checks = 0, errors = 0;
   bit done = 0;

   // behavioural reference model
   bit m_rdy [2], m_err [2];
   bit m_cal, m_nox, m_l1, m_l2;
   bit sq [$];

   always #(CLK_P/2) clk = ~clk;

   conv_status_reg uut (.*);

   function automatic logic [7:0] mbyte();
      return {m_rdy[0], m_rdy[1], m_cal, m_nox, m_err[0], m_err[1], 1'b0, m_l2};
   endfunction

   function automatic string btag(int i);
      case (i)
         7: return "R3/R4 main ready";
         6: return "R3/R4 aux ready";
         5: return "R6 cal";
         4: return "R7 noref";
         3: return "R8 main err";
         2: return "R8 aux err";
         1: return "R2 reserved";
         default: return "R9 lock";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rdy = '{0, 0}; m_err = '{0, 0};
         m_cal = 0; m_nox = 0; m_l1 = 0; m_l2 = 0;
         sq.delete();
      end else begin
         logic [7:0] old;
         old = mbyte();
         if (ser_start && reg_addr == 4'd0 && sq.size() == 0)  // R10
            for (int b = 7; b >= 0; b--) sq.push_back(old[b]);
         for (int c = 0; c < 2; c++) begin
            bit cl, es;
            cl = clamp[c] || (c == 0 && m_nox);
            es = (res_wr[c] && cl) || (cal_done[c] && cal_fault[c]);
            if (res_wr[c] || cal_done[c]) m_rdy[c] = 1;
            else if (data_rd[c] || upd_pend[c] || mode_wr) m_rdy[c] = 0;
            if (es) m_err[c] = 1;
            else if (mode_wr) m_err[c] = 0;
         end
         if (cal_done != 0) m_cal = 1;
         else if (mode_wr) m_cal = 0;
         m_nox = main_en && ref_fault;
         m_l2 = m_l1;
         m_l1 = pll_lock;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [7:0] exp;
         exp = (reg_addr == 4'd0) ? mbyte() : 8'h00;
         for (int i = 0; i < 8; i++) begin
            checks++;
            if (rd_data[i] !== exp[i]) begin
               errors++;
               $display("FAIL %s bit %0d (addr %0d): got %b exp %b", btag(i), i, reg_addr, rd_data[i], exp[i]);
            end
         end
         checks++;
         if (main_force_ones !== m_nox) begin
            errors++;
            $display("FAIL R7 force_ones: got %b exp %b", main_force_ones, m_nox);
         end
         checks++;
         if (ser_busy !== (sq.size() != 0)) begin
            errors++;
            $display("FAIL R10 busy: got %b exp %b", ser_busy, sq.size() != 0);
         end
         if (sq.size() != 0) begin
            bit e;
            e = sq.pop_front();
            checks++;
            if (ser_out !== e) begin
               errors++;
               $display("FAIL R10 serial bit: got %b exp %b", ser_out, e);
            end
         end
      end
   end

   task automatic tick(int n = 1);
      repeat (n) begin
         @(posedge clk); #1;
         res_wr = 0; cal_done = 0; clamp = 0; cal_fault = 0;
         upd_pend = 0; data_rd = 0; mode_wr = 0; ser_start = 0;
      end
   endtask

   // result write preceded by an update-pending pulse
   task automatic result(int c, bit clmp);
      upd_pend[c] = 1;
      tick(PEND_LEAD);
      res_wr[c] = 1; clamp[c] = clmp;
      tick();
   endtask

   task automatic serial_read();
      ser_start = 1;
      tick(9);
   endtask

   initial begin
      #(CLK_P * WDOG);
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      checks++;  // R1 reset state
      if (rd_data !== 8'h00 || ser_busy !== 1'b0 || main_force_ones !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: got %h/%b exp 00/0", rd_data, ser_busy);
      end
      @(posedge clk); #1; rst_n = 1;
      tick(2);
      // R3, R4: set, read clear, pending clear
      result(0, 0);
      result(1, 1);
      data_rd[0] = 1; tick();
      tick(2);
      result(0, 0);
      upd_pend[0] = 1; tick();
      // R3: set beats clear in same cycle
      res_wr[0] = 1; data_rd[0] = 1; tick();
      res_wr[1] = 1; upd_pend[1] = 1; mode_wr = 1; tick();
      // R5: mode write clears
      mode_wr = 1; tick(2);
      // R6, R8: calibration with aux fault
      cal_done = 2'b11; cal_fault = 2'b10; tick(2);
      cal_done[0] = 1; mode_wr = 1; tick();
      mode_wr = 1; tick();
      // R7, R8: reference fault gated by enable
      ref_fault = 1; tick(2);
      main_en = 1; tick(2);
      result(0, 0);
      result(1, 0);
      main_en = 0; tick(2);
      ref_fault = 0;
      // R9: lock synchronizer
      pll_lock = 1; tick(4);
      // R10: serial reads, restart attempts during shift
      serial_read();
      result(0, 1);
      ser_start = 1; tick(3);
      ser_start = 1; tick(5);
      ser_start = 1; tick(9);
      // R2: other addresses read zero and do not start serial
      reg_addr = 4'd5; ser_start = 1; tick(3);
      reg_addr = 4'd15; tick(2);
      reg_addr = 4'd0;
      pll_lock = 0; tick(3);
      // random phase covering collisions
      for (int k = 0; k < 4000; k++) begin
         res_wr    = 2'($urandom_range(3)) & {($urandom_range(99) < 8), ($urandom_range(99) < 8)};
         cal_done  = {($urandom_range(99) < 3), ($urandom_range(99) < 3)};
         clamp     = 2'($urandom_range(3));
         cal_fault = 2'($urandom_range(3));
         upd_pend  = {($urandom_range(99) < 6), ($urandom_range(99) < 6)};
         data_rd   = {($urandom_range(99) < 6), ($urandom_range(99) < 6)};
         mode_wr   = ($urandom_range(99) < 4);
         ser_start = ($urandom_range(99) < 10);
         if ($urandom_range(99) < 5) main_en   = ~main_en;
         if ($urandom_range(99) < 5) ref_fault = ~ref_fault;
         if ($urandom_range(99) < 3) pll_lock  = ~pll_lock;
         reg_addr = ($urandom_range(99) < 10) ? 4'($urandom_range(15)) : 4'd0;
         tick();
      end
      reg_addr = 0;
      tick(12);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule